// File: doc/BRIEF.md
# Interrupt Controller Command Front End

This block is the byte-wide register interface of an eight-line programmable interrupt controller. Software reaches it through two addresses with write and read strobes. Writes at address 0 are decoded into one of three kinds: a start-of-initialization word, an end-of-interrupt/priority command, or a read-select command. Writes at address 1 are interpreted by an initialization sequencer. Outside initialization they load the interrupt mask. During initialization they load, in turn, the vector base, the cascade information and the mode word.

The block holds the configuration that the rest of the controller uses: the mask, the vector base, the cascade bits, the auto end-of-interrupt flag, the trigger mode and the read-select flag. End-of-interrupt commands go to the priority core as single-cycle pulses. Each pulse carries a flag that marks it specific or nonspecific, plus a line number. Reads return the request or in-service register supplied by the core, or the mask.

Top module: `pic_cmd_front`

## Requirements
- R1: After reset, init_step is 0, mask_q, vec_base, casc_bits, auto_eoi and edge_mode are 0, and the read-select flag picks the request register.
- R2: A write at address 0 with data bit 4 set clears mask_q, sets edge_mode from bit 3, records cascade mode when bit 1 is 0, records that a mode word is expected when bit 0 is 1, and sets init_step to 1 on the next clock.
- R3: A start-of-initialization write with bit 0 clear forces auto_eoi to 0.
- R4: A write at address 0 with bits 4:3 = 00 and bits 7:5 = 001 raises eoi_pulse for exactly one cycle after the write edge, with eoi_specific = 0.
- R5: A write at address 0 with bits 4:3 = 00 and bits 7:5 = 011 raises eoi_pulse for one cycle with eoi_specific = 1 and eoi_line equal to data bits 2:0. The other six codes of bits 7:5 raise no pulse.
- R6: A write at address 0 with bits 4:3 = 01 changes the read-select flag to data bit 0 only when data bit 1 is 1. Bit 0 = 1 selects the request register and 0 selects the in-service register.
- R7: A write at address 1 while init_step is 0 loads mask_q with the data.
- R8: A write at address 1 while init_step is 1 loads vec_base with the data with bits 2:0 forced to 0. init_step then goes to 2 in cascade mode. Otherwise casc_bits is cleared and init_step goes to 0.
- R9: A write at address 1 while init_step is 2 loads casc_bits with all eight data bits when is_master is 1, or with data bits 2:0 zero-extended when is_master is 0. init_step then goes to 3 if a mode word is expected, and otherwise to 0.
- R10: A write at address 1 while init_step is 3 sets auto_eoi from data bit 1, leaves mask_q unchanged and returns init_step to 0.
- R11: While rd_en is high, rdata equals mask_q at address 1. At address 0 it equals req_vec or isr_vec, chosen by the read-select flag. While rd_en is low, rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | Role select: 1 master, 0 slave |
| addr | input | 1 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| req_vec | input | 8 | Request register from the priority core |
| isr_vec | input | 8 | In-service register from the priority core |
| rdata | output | 8 | Read data |
| mask_q | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| casc_bits | output | 8 | Slave-present mask (master) or slave ID (slave) |
| auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| edge_mode | output | 1 | 1 edge-triggered, 0 level-triggered |
| init_step | output | 2 | Initialization sequencer step |
| eoi_pulse | output | 1 | One-cycle end-of-interrupt command |
| eoi_specific | output | 1 | The pulse names a specific line |
| eoi_line | output | 3 | Line for a specific end-of-interrupt |

## Verification
The bench runs every combination of role, cascade mode and mode-word-expected through the initialization sequence. A sequencer that skipped the wrong step would leave init_step stranded at 2 or 3, or would swallow the next mask write as configuration. Every code and line of the address-0 command byte is swept. A decoder that misread bits 7:5 would pulse on a no-operation or rotate code, or would report the wrong line. All 256 mask values are read back. The read-select command is also sent with bit 1 clear, where a careless decoder would flip the selection. A stale auto_eoi that is not cleared by a short initialization is caught as well.

// File: rtl/pic_front_pkg.sv
package pic_front_pkg;
   typedef enum logic [1:0] {
      STEP_IDLE = 2'd0,
      STEP_BASE = 2'd1,
      STEP_CASC = 2'd2,
      STEP_MODE = 2'd3
   } init_step_e;

   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_INIT  = 2'd1,
      CMD_EOI   = 2'd2,
      CMD_RDSEL = 2'd3
   } cmd_kind_e;

   localparam logic [2:0] OP_EOI_ANY  = 3'b001;
   localparam logic [2:0] OP_EOI_LINE = 3'b011;
endpackage

// File: rtl/pic_word_decode.sv
module pic_word_decode
   import pic_front_pkg::*;
#(
   parameter int DW = 8,
   localparam int LW = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          addr,
   input  logic [DW-1:0] wdata,
   output cmd_kind_e     kind,
   output logic          eoi_pulse,
   output logic          eoi_specific,
   output logic [LW-1:0] eoi_line
);
   logic op_wr;
   logic eoi_any_hit;
   logic eoi_line_hit;

   assign op_wr = wr_en && !addr;

   always_comb begin
      kind = CMD_NONE;
      if (op_wr) begin
         if (wdata[4])
            kind = CMD_INIT;
         else if (wdata[3] == 1'b0)
            kind = CMD_EOI;
         else
            kind = CMD_RDSEL;
      end
   end

   assign eoi_any_hit  = (kind == CMD_EOI) && (wdata[7:5] == OP_EOI_ANY);
   assign eoi_line_hit = (kind == CMD_EOI) && (wdata[7:5] == OP_EOI_LINE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoi_pulse    <= 1'b0;
         eoi_specific <= 1'b0;
         eoi_line     <= '0;
      end else begin
         eoi_pulse    <= eoi_any_hit || eoi_line_hit;
         eoi_specific <= eoi_line_hit;
         if (eoi_line_hit)
            eoi_line <= wdata[LW-1:0];
      end
   end

   // R4
   eoi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_pulse |-> $past(wr_en && !addr && !wdata[4] && !wdata[3]));
   // R5
   eoi_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_wr && wdata[7:3] == 5'b01100) |=> (eoi_pulse && eoi_specific && eoi_line == $past(wdata[LW-1:0])));
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
   import pic_front_pkg::*;
#(
   parameter int DW = 8,
   parameter int ID_W = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          is_master,
   input  cmd_kind_e     kind,
   input  logic          cfg_wr,
   input  logic [DW-1:0] wdata,
   output init_step_e    step,
   output logic [DW-1:0] mask_q,
   output logic [DW-1:0] vec_base,
   output logic [DW-1:0] casc_bits,
   output logic          auto_eoi,
   output logic          edge_mode,
   output logic          read_req
);
   logic cascade_q;
   logic want_mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step        <= STEP_IDLE;
         mask_q      <= '0;
         vec_base    <= '0;
         casc_bits   <= '0;
         auto_eoi    <= 1'b0;
         edge_mode   <= 1'b0;
         read_req    <= 1'b1;
         cascade_q   <= 1'b0;
         want_mode_q <= 1'b0;
      end else if (kind == CMD_INIT) begin
         mask_q      <= '0;
         edge_mode   <= wdata[3];
         cascade_q   <= !wdata[1];
         want_mode_q <= wdata[0];
         if (!wdata[0])
            auto_eoi <= 1'b0;
         step <= STEP_BASE;
      end else if (kind == CMD_RDSEL) begin
         if (wdata[1])
            read_req <= wdata[0];
      end else if (cfg_wr) begin
         unique case (step)
            STEP_IDLE: mask_q <= wdata;
            STEP_BASE: begin
               vec_base <= {wdata[DW-1:ID_W], {ID_W{1'b0}}};
               if (cascade_q)
                  step <= STEP_CASC;
               else begin
                  casc_bits <= '0;
                  step      <= STEP_IDLE;
               end
            end
            STEP_CASC: begin
               casc_bits <= is_master ? wdata : {{(DW-ID_W){1'b0}}, wdata[ID_W-1:0]};
               step      <= want_mode_q ? STEP_MODE : STEP_IDLE;
            end
            STEP_MODE: begin
               auto_eoi <= wdata[1];
               step     <= STEP_IDLE;
            end
            default: step <= STEP_IDLE;
         endcase
      end
   end

   // R2
   init_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CMD_INIT) |=> (step == STEP_BASE && mask_q == '0));
   // R7
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && kind == CMD_NONE && step == STEP_IDLE) |=> (mask_q == $past(wdata)));
   // R8
   no_step_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step == STEP_IDLE) |=> (step == STEP_IDLE || step == STEP_BASE));
   // R10
   mode_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && kind == CMD_NONE && step == STEP_MODE) |=> (step == STEP_IDLE && $stable(mask_q)));
endmodule

// File: rtl/pic_read_mux.sv
module pic_read_mux #(
   parameter int DW = 8,
   parameter bit REG_OUT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic          addr,
   input  logic          read_req,
   input  logic [DW-1:0] req_vec,
   input  logic [DW-1:0] isr_vec,
   input  logic [DW-1:0] mask_q,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] sel_d;

   always_comb begin
      if (!rd_en)
         sel_d = '0;
      else if (addr)
         sel_d = mask_q;
      else
         sel_d = read_req ? req_vec : isr_vec;
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= sel_d;
         end
      end else begin : g_comb
         assign rdata = sel_d;
         // R11
         mask_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && addr) |-> (rdata == mask_q));
         // R11
         idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en |-> (rdata == '0));
      end
   endgenerate
endmodule

// File: rtl/pic_cmd_front.sv
module pic_cmd_front
   import pic_front_pkg::*;
#(
   parameter int DW = 8,
   parameter bit REG_RDATA = 1'b0,
   localparam int LW = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          is_master,
   input  logic          addr,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] req_vec,
   input  logic [DW-1:0] isr_vec,
   output logic [DW-1:0] rdata,
   output logic [DW-1:0] mask_q,
   output logic [DW-1:0] vec_base,
   output logic [DW-1:0] casc_bits,
   output logic          auto_eoi,
   output logic          edge_mode,
   output logic [1:0]    init_step,
   output logic          eoi_pulse,
   output logic          eoi_specific,
   output logic [LW-1:0] eoi_line
);
   generate
      if (DW != 8) begin : g_bad_width
         $error("pic_cmd_front: command byte layout needs DW == 8");
      end
   endgenerate

   cmd_kind_e  kind;
   init_step_e step;
   logic       read_req;
   logic       cfg_wr;

   assign cfg_wr    = wr_en && addr;
   assign init_step = step;

   pic_word_decode #(.DW(DW)) u_decode (
      .clk, .rst_n, .wr_en, .addr, .wdata,
      .kind, .eoi_pulse, .eoi_specific, .eoi_line
   );

   pic_init_seq #(.DW(DW), .ID_W(LW)) u_seq (
      .clk, .rst_n, .is_master, .kind, .cfg_wr, .wdata,
      .step, .mask_q, .vec_base, .casc_bits, .auto_eoi, .edge_mode, .read_req
   );

   pic_read_mux #(.DW(DW), .REG_OUT(REG_RDATA)) u_rd (
      .clk, .rst_n, .rd_en, .addr, .read_req, .req_vec, .isr_vec, .mask_q, .rdata
   );

   // R3
   short_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr && wdata[4] && !wdata[0]) |=> !auto_eoi);
endmodule

// File: tb/pic_cmd_front_tb.sv
module pic_cmd_front_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       is_master = 1'b1;
   logic       addr = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] req_vec = 8'h3C;
   logic [7:0] isr_vec = 8'hC1;
   logic [7:0] rdata, mask_q, vec_base, casc_bits;
   logic       auto_eoi, edge_mode, eoi_pulse, eoi_specific;
   logic [1:0] init_step;
   logic [2:0] eoi_line;
   int checks = 0;
   int fails = 0;

   always #10 clk = ~clk;

   pic_cmd_front dut_i (
      .clk, .rst_n, .is_master, .addr, .wr_en, .rd_en, .wdata, .req_vec, .isr_vec,
      .rdata, .mask_q, .vec_base, .casc_bits, .auto_eoi, .edge_mode, .init_step,
      .eoi_pulse, .eoi_specific, .eoi_line
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #2 d = rdata;
      rd_en = 1'b0;
   endtask

   initial begin
      logic [7:0] r;
      logic       exp_auto;
      logic [7:0] exp_casc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 step", init_step, 0);
      check("R1 mask", mask_q, 0);
      check("R1 base", vec_base, 0);
      check("R1 casc", casc_bits, 0);
      check("R1 auto", auto_eoi, 0);
      check("R1 edge", edge_mode, 0);
      rd(1'b0, r);
      check("R1 readsel", r, req_vec);
      rd(1'b1, r);
      check("R11 idle", rdata, 0);

      // R7 R11 mask sweep
      for (int v = 0; v < 256; v++) begin
         wr(1'b1, v[7:0]);
         rd(1'b1, r);
         check("R7 mask", r, v);
      end

      // R6 read select
      wr(1'b0, 8'h0A);
      rd(1'b0, r);
      check("R6 isr", r, isr_vec);
      wr(1'b0, 8'h09);
      rd(1'b0, r);
      check("R6 ignored", r, isr_vec);
      wr(1'b0, 8'h0B);
      rd(1'b0, r);
      check("R6 req", r, req_vec);
      wr(1'b0, 8'h08);
      rd(1'b0, r);
      check("R6 ignored2", r, req_vec);

      // R4 R5 sweep all codes and lines
      for (int c = 0; c < 8; c++) begin
         for (int l = 0; l < 8; l++) begin
            wr(1'b0, {c[2:0], 2'b00, l[2:0]});
            check("R5 pulse", eoi_pulse, (c == 1 || c == 3));
            if (c == 1) check("R4 nonspecific", eoi_specific, 0);
            if (c == 3) begin
               check("R5 specific", eoi_specific, 1);
               check("R5 line", eoi_line, l);
            end
            @(negedge clk);
            check("R4 one cycle", eoi_pulse, 0);
         end
      end
      check("R5 mask kept", mask_q, 8'hFF);

      // R2 R3 R8 R9 R10 init sequences
      exp_auto = 1'b0;
      exp_casc = 8'h00;
      for (int role = 0; role < 2; role++) begin
         for (int cs = 0; cs < 2; cs++) begin
            for (int m4 = 0; m4 < 2; m4++) begin
               is_master = role[0];
               wr(1'b1, 8'hA5);
               wr(1'b0, {3'b000, 1'b1, role[0] ^ cs[0], 1'b0, !cs[0], m4[0]});
               if (!m4[0]) exp_auto = 1'b0;
               check("R2 step", init_step, 1);
               check("R2 mask", mask_q, 0);
               check("R2 edge", edge_mode, role[0] ^ cs[0]);
               check("R3 auto", auto_eoi, exp_auto);
               wr(1'b1, 8'h45 + 8'(8 * (role * 4 + cs * 2 + m4)));
               check("R8 base", vec_base, (8'h45 + 8'(8 * (role * 4 + cs * 2 + m4))) & 8'hF8);
               if (!cs[0]) begin
                  exp_casc = 8'h00;
                  check("R8 step", init_step, 0);
               end else begin
                  check("R8 step", init_step, 2);
                  wr(1'b1, 8'hD6);
                  exp_casc = role[0] ? 8'hD6 : 8'h06;
                  check("R9 step", init_step, m4[0] ? 3 : 0);
                  if (m4[0]) begin
                     wr(1'b1, 8'h02);
                     exp_auto = 1'b1;
                     check("R10 step", init_step, 0);
                     check("R10 mask", mask_q, 0);
                  end
               end
               check("R9 casc", casc_bits, exp_casc);
               check("R10 auto", auto_eoi, exp_auto);
               wr(1'b1, 8'h5A);
               check("R7 after init", mask_q, 8'h5A);
            end
         end
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule